// File: doc/BRIEF.md
# Windowed framebuffer address sequencer

This block turns a stream of pixel bytes into write cycles for a greyscale framebuffer. Each byte holds two 4-bit pixels. The buffer has 64 bytes per row and 80 rows. The block keeps a column pointer and a row pointer. These pointers move inside a rectangular window that the command parser sets up. For every byte it accepts, the block issues one write whose address is the column pointer plus the row pointer times 64. It then moves the pointers.

Two orders of movement are offered. In the horizontal order the column moves first and the row moves when the column wraps. In the vertical order the row moves first and the column moves when the row wraps. One bit of a remap byte selects the order. Every accepted byte also raises a redraw-pending flag, and the scan-out side clears that flag with a pulse.

Bytes arrive on a valid/ready stream. `data_ready` is low only in a cycle where a window or remap load is presented. No other condition stalls the stream. A byte offered while `data_ready` is low is not taken, so the source must hold it until a cycle where both valid and ready are high. The write port has no back-pressure. The RAM behind it must accept a write every cycle.

Top module: `fb_addr_seq`

## Requirements
- R1: After reset the column window is 0 to 63, the row window is 0 to 79, both pointers are 0, the order is horizontal, and `wr_en` and `redraw_pending` are 0. The first byte accepted after reset is therefore written to address 0.
- R2: A byte accepted at a clock edge (`data_valid` and `data_ready` both high) gives `wr_en` = 1 for exactly the following cycle. In that cycle `wr_addr` = column + row*64, using the pointers as they stood before the edge, and `wr_data` is the byte. In every other cycle `wr_en` is 0.
- R3: With bit 2 of the stored remap byte clear, each accepted byte advances the column. If the column was at or past its end, the column reloads its start and the row advances. If the row was at or past its end, the row reloads its start instead.
- R4: With bit 2 of the remap byte set, each accepted byte advances the row. If the row was at or past its end, the row reloads its start and the column advances. If the column was at or past its end, the column reloads its start instead. The other bits of the remap byte have no effect.
- R5: A column load stores start and end as the input values modulo 64. A row load stores them modulo 80. Either load moves that pointer to the new start.
- R6: If a window end is below its start, that pointer reloads its start every time it advances.
- R7: `data_ready` is 0 in a cycle where `col_load`, `row_load` or `remap_load` is high, and 1 otherwise. A byte offered in such a cycle causes no write and no pointer move.
- R8: `redraw_pending` becomes 1 after an accepted byte. It becomes 0 after a `redraw_clear` pulse. If both happen at the same edge, the flag ends up set.
- R9: A load takes effect at its own edge. A byte accepted in the very next cycle is written at the new window start, and the new order applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_valid | input | 1 | Pixel byte offered |
| data_ready | output | 1 | Byte can be taken this cycle |
| data_byte | input | 8 | Pixel byte (two 4-bit pixels) |
| col_load | input | 1 | Load the column window |
| col_lo | input | 8 | Column window start (taken mod 64) |
| col_hi | input | 8 | Column window end (taken mod 64) |
| row_load | input | 1 | Load the row window |
| row_lo | input | 8 | Row window start (taken mod 80) |
| row_hi | input | 8 | Row window end (taken mod 80) |
| remap_load | input | 1 | Store `remap_byte` |
| remap_byte | input | 8 | Remap byte; bit 2 selects vertical order |
| redraw_clear | input | 1 | Scan-out acknowledges the redraw |
| wr_en | output | 1 | Framebuffer write strobe |
| wr_addr | output | 13 | Framebuffer byte address |
| wr_data | output | 8 | Byte to write |
| redraw_pending | output | 1 | Buffer changed since the last clear |

## Verification
The bound checker covers the stream and write port on every cycle:
- a write follows every accepted byte and nothing else;
- the data is carried through unchanged;
- the address stays within the buffer;
- ready drops during loads;
- the redraw flag is set by data and cleared by a lone clear pulse.

The values of the addresses depend on the window walk, and only the bench's cycle-by-cycle reference model shows them. That includes the horizontal and vertical wrap sequences, the reversed windows, the modulo reduction of loaded bounds, and the fact that a load applies to the very next byte.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;
  typedef enum logic {
    ORDER_HORIZ = 1'b0,
    ORDER_VERT  = 1'b1
  } scan_order_e;

  // Remap bit that selects row-first stepping.
  localparam int VERT_BIT = 2;
endpackage

// File: rtl/fbseq_reduce.sv
// Reduces an incoming bound to the range 0..LIMIT-1.
module fbseq_reduce #(
  parameter int IN_W  = 8,
  parameter int LIMIT = 80,
  parameter int OUT_W = 7
) (
  input  logic [IN_W-1:0]  value_in,
  output logic [OUT_W-1:0] value_out
);
  localparam int NSUB = ((1 << IN_W) + LIMIT - 1) / LIMIT;

  generate
    if ((LIMIT & (LIMIT - 1)) == 0) begin : g_pow2
      assign value_out = value_in[OUT_W-1:0];
    end else begin : g_sub
      logic [IN_W-1:0] acc;
      always_comb begin
        acc = value_in;
        for (int i = 0; i < NSUB; i++) begin
          if (acc >= IN_W'(LIMIT)) acc = acc - IN_W'(LIMIT);
        end
      end
      assign value_out = acc[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fbseq_axis.sv
// One pointer with its window start/end.
module fbseq_axis #(
  parameter int W        = 6,
  parameter int RESET_HI = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  input  logic         step,
  output logic [W-1:0] ptr,
  output logic         at_end
);
  logic [W-1:0] lo_q, hi_q;

  assign at_end = (ptr >= hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= W'(RESET_HI);
      ptr  <= '0;
    end else if (load) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
      ptr  <= lo_in;
    end else if (step) begin
      ptr <= at_end ? lo_q : ptr + W'(1);
    end
  end
endmodule

// File: rtl/fbseq_wport.sv
// Registered write port and redraw flag.
module fbseq_wport #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          clear,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          redraw
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      redraw  <= 1'b0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_addr <= addr_in;
        wr_data <= data_in;
      end
      if (accept)     redraw <= 1'b1;
      else if (clear) redraw <= 1'b0;
    end
  end
endmodule

// File: rtl/fb_addr_seq.sv
module fb_addr_seq
  import fbseq_pkg::*;
#(
  parameter int  COL_BYTES = 64,
  parameter int  ROW_COUNT = 80,
  parameter int  BYTE_W    = 8,
  localparam int ADDR_W    = $clog2(COL_BYTES * ROW_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              col_load,
  input  logic [BYTE_W-1:0] col_lo,
  input  logic [BYTE_W-1:0] col_hi,
  input  logic              row_load,
  input  logic [BYTE_W-1:0] row_lo,
  input  logic [BYTE_W-1:0] row_hi,
  input  logic              remap_load,
  input  logic [BYTE_W-1:0] remap_byte,
  input  logic              redraw_clear,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              redraw_pending
);
  localparam int CW = $clog2(COL_BYTES);
  localparam int RW = $clog2(ROW_COUNT);

  logic          accept;
  logic [CW-1:0] c_lo, c_hi, c_ptr;
  logic [RW-1:0] r_lo, r_hi, r_ptr;
  logic          c_end, r_end, c_step, r_step;
  logic [ADDR_W-1:0] lin_addr;
  scan_order_e   order_q;

  assign data_ready = !(col_load || row_load || remap_load);
  assign accept     = data_valid && data_ready;

  fbseq_reduce #(.IN_W(BYTE_W), .LIMIT(COL_BYTES), .OUT_W(CW)) u_red_clo (.value_in(col_lo), .value_out(c_lo));
  fbseq_reduce #(.IN_W(BYTE_W), .LIMIT(COL_BYTES), .OUT_W(CW)) u_red_chi (.value_in(col_hi), .value_out(c_hi));
  fbseq_reduce #(.IN_W(BYTE_W), .LIMIT(ROW_COUNT), .OUT_W(RW)) u_red_rlo (.value_in(row_lo), .value_out(r_lo));
  fbseq_reduce #(.IN_W(BYTE_W), .LIMIT(ROW_COUNT), .OUT_W(RW)) u_red_rhi (.value_in(row_hi), .value_out(r_hi));

  always_ff @(posedge clk) begin
    if (!rst_n)          order_q <= ORDER_HORIZ;
    else if (remap_load) order_q <= remap_byte[VERT_BIT] ? ORDER_VERT : ORDER_HORIZ;
  end

  // The leading axis steps on every byte; the other steps when the leader wraps.
  always_comb begin
    unique case (order_q)
      ORDER_VERT: begin
        r_step = accept;
        c_step = accept && r_end;
      end
      default: begin
        c_step = accept;
        r_step = accept && c_end;
      end
    endcase
  end

  fbseq_axis #(.W(CW), .RESET_HI(COL_BYTES - 1)) u_col (
    .clk(clk), .rst_n(rst_n), .load(col_load), .lo_in(c_lo), .hi_in(c_hi),
    .step(c_step), .ptr(c_ptr), .at_end(c_end)
  );

  fbseq_axis #(.W(RW), .RESET_HI(ROW_COUNT - 1)) u_row (
    .clk(clk), .rst_n(rst_n), .load(row_load), .lo_in(r_lo), .hi_in(r_hi),
    .step(r_step), .ptr(r_ptr), .at_end(r_end)
  );

  assign lin_addr = ADDR_W'(r_ptr) * ADDR_W'(COL_BYTES) + ADDR_W'(c_ptr);

  fbseq_wport #(.AW(ADDR_W), .DW(BYTE_W)) u_wport (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr_in(lin_addr),
    .data_in(data_byte), .clear(redraw_clear), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .redraw(redraw_pending)
  );
endmodule

// File: rtl/fb_addr_seq_chk.sv
module fb_addr_seq_chk #(
  parameter int COL_BYTES = 64,
  parameter int ROW_COUNT = 80,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_valid,
  input logic              data_ready,
  input logic [BYTE_W-1:0] data_byte,
  input logic              col_load,
  input logic              row_load,
  input logic              remap_load,
  input logic              redraw_clear,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              redraw_pending
);
  AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && data_ready) |=> wr_en); // R2
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(data_valid && data_ready) |=> !wr_en); // R2
  AST_DATA_CARRIED: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && data_ready) |=> (wr_data == $past(data_byte))); // R2
  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (32'(wr_addr) < COL_BYTES * ROW_COUNT)); // R2
  AST_STALL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (col_load || row_load || remap_load) |-> !data_ready); // R7
  AST_READY_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n) !(col_load || row_load || remap_load) |-> data_ready); // R7
  AST_REDRAW_SET: assert property (@(posedge clk) disable iff (!rst_n) (data_valid && data_ready) |=> redraw_pending); // R8
  AST_REDRAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (redraw_clear && !(data_valid && data_ready)) |=> !redraw_pending); // R8
endmodule

bind fb_addr_seq fb_addr_seq_chk #(
  .COL_BYTES(COL_BYTES), .ROW_COUNT(ROW_COUNT), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .data_ready(data_ready),
  .data_byte(data_byte), .col_load(col_load), .row_load(row_load),
  .remap_load(remap_load), .redraw_clear(redraw_clear), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .redraw_pending(redraw_pending)
);

// File: tb/sim_fb_addr_seq.sv
`timescale 1ns/1ps
module sim_fb_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_valid = 1'b0, col_load = 1'b0, row_load = 1'b0, remap_load = 1'b0, redraw_clear = 1'b0;
  logic [7:0] data_byte = '0, col_lo = '0, col_hi = '0, row_lo = '0, row_hi = '0, remap_byte = '0;
  logic data_ready, wr_en, redraw_pending;
  logic [12:0] wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  fb_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .data_ready(data_ready),
    .data_byte(data_byte), .col_load(col_load), .col_lo(col_lo), .col_hi(col_hi),
    .row_load(row_load), .row_lo(row_lo), .row_hi(row_hi), .remap_load(remap_load),
    .remap_byte(remap_byte), .redraw_clear(redraw_clear), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .redraw_pending(redraw_pending)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference model state
  int mc, mr, mcs, mce, mrs, mre, vert, mred;
  int exp_wen, exp_addr, exp_dat;
  logic [7:0] ref_mem[int];
  logic [7:0] dut_mem[int];

  task automatic chk(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (wr_en === 1'b1) dut_mem[int'(wr_addr)] = wr_data;
    if (!rst_n) begin
      mc = 0; mr = 0; mcs = 0; mce = 63; mrs = 0; mre = 79; vert = 0; mred = 0;
      exp_wen = 0; exp_addr = 0; exp_dat = 0;
    end else begin
      automatic int busy = int'(col_load || row_load || remap_load);
      automatic int acc = int'(data_valid) & (1 - busy);
      chk("R7", int'(data_ready), 1 - busy, "data_ready");
      exp_wen = acc;
      if (acc != 0) begin
        exp_addr = mc + mr * 64;
        exp_dat  = int'(data_byte);
        ref_mem[exp_addr] = data_byte;
        if (vert == 0) begin
          mc++;
          if (mc > mce) begin mc = mcs; mr++; end
          if (mr > mre) mr = mrs;
        end else begin
          mr++;
          if (mr > mre) begin mr = mrs; mc++; end
          if (mc > mce) mc = mcs;
        end
        mred = 1;
      end else if (redraw_clear) mred = 0;
      if (col_load) begin mcs = int'(col_lo) % 64; mce = int'(col_hi) % 64; mc = mcs; end
      if (row_load) begin mrs = int'(row_lo) % 80; mre = int'(row_hi) % 80; mr = mrs; end
      if (remap_load) vert = int'(remap_byte[2]);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", int'(wr_en), exp_wen, "wr_en");
      if (exp_wen != 0) begin
        chk(cur_req, int'(wr_addr), exp_addr, "wr_addr");
        chk("R2", int'(wr_data), exp_dat, "wr_data");
      end
      chk("R8", int'(redraw_pending), mred, "redraw_pending");
    end
  end

  task automatic quiet();
    data_valid = 0; col_load = 0; row_load = 0; remap_load = 0; redraw_clear = 0;
  endtask
  task automatic idle(); @(negedge clk); quiet(); endtask
  task automatic push(input logic [7:0] b);
    @(negedge clk); quiet(); data_valid = 1; data_byte = b;
  endtask
  task automatic cols(input logic [7:0] s, input logic [7:0] e);
    @(negedge clk); quiet(); col_load = 1; col_lo = s; col_hi = e;
  endtask
  task automatic rows(input logic [7:0] s, input logic [7:0] e);
    @(negedge clk); quiet(); row_load = 1; row_lo = s; row_hi = e;
  endtask
  task automatic remap(input logic [7:0] r);
    @(negedge clk); quiet(); remap_load = 1; remap_byte = r;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(wr_en), 0, "wr_en after reset");
    chk("R1", int'(redraw_pending), 0, "redraw after reset");
    chk("R1", int'(data_ready), 1, "ready after reset");
    cur_req = "R1";
    push(8'h11);
    idle();
    chk("R1", int'(wr_addr), 0, "first address");
    // R3: default horizontal order
    cur_req = "R3";
    for (int i = 0; i < 3; i++) push(8'(8'h20 + i));
    // R5: bounds taken modulo, R3 wrap inside window
    cur_req = "R5";
    cols(8'd70, 8'd73);
    rows(8'd200, 8'd201);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) push(8'(8'h30 + i));
    // R4: vertical order, other remap bits ignored
    cur_req = "R4";
    remap(8'h04);
    cols(8'd10, 8'd11);
    rows(8'd5, 8'd7);
    for (int i = 0; i < 8; i++) push(8'(8'h40 + i));
    remap(8'hFF);
    cols(8'd2, 8'd3);
    rows(8'd1, 8'd2);
    for (int i = 0; i < 6; i++) push(8'(8'h48 + i));
    // R6: reversed windows
    cur_req = "R6";
    remap(8'hFB);
    cols(8'd20, 8'd18);
    rows(8'd3, 8'd4);
    for (int i = 0; i < 5; i++) push(8'(8'h50 + i));
    remap(8'h04);
    rows(8'd9, 8'd6);
    cols(8'd30, 8'd31);
    for (int i = 0; i < 4; i++) push(8'(8'h58 + i));
    // R7: byte offered during a load is not taken
    cur_req = "R7";
    @(negedge clk); quiet(); data_valid = 1; data_byte = 8'hEE; col_load = 1; col_lo = 8'd5; col_hi = 8'd6;
    @(negedge clk); quiet(); data_valid = 1; data_byte = 8'hED; remap_load = 1; remap_byte = 8'h00;
    idle();
    chk("R7", int'(wr_en), 0, "no write for stalled byte");
    // R9: byte right after a load lands at new start
    cur_req = "R9";
    rows(8'd12, 8'd13);
    push(8'h61);
    idle();
    chk("R9", int'(wr_addr), 12 * 64 + 5, "address after load");
    // R8: redraw clear, and set winning over clear
    @(negedge clk); quiet(); redraw_clear = 1;
    idle();
    chk("R8", int'(redraw_pending), 0, "cleared by pulse");
    @(negedge clk); quiet(); redraw_clear = 1; data_valid = 1; data_byte = 8'h62;
    idle();
    chk("R8", int'(redraw_pending), 1, "set wins over clear");
    // R3: full-width walk with gaps over bottom rows, wrapping to window start
    cur_req = "R3";
    cols(8'd0, 8'd63);
    rows(8'd78, 8'd79);
    for (int i = 0; i < 140; i++) begin
      push(8'(i * 7 + 3));
      if (i % 9 == 4) idle();
    end
    // R4: vertical walk with gaps
    cur_req = "R4";
    remap(8'h04);
    cols(8'd60, 8'd63);
    rows(8'd75, 8'd79);
    for (int i = 0; i < 30; i++) begin
      push(8'(i * 5 + 1));
      if (i % 4 == 1) idle();
    end
    idle();
    idle();
    // R2: memory image written through the port
    begin
      automatic int bad = 0;
      foreach (ref_mem[a]) if (!dut_mem.exists(a) || dut_mem[a] !== ref_mem[a]) bad++;
      chk("R2", bad, 0, "memory mismatches");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule